// File: doc/BRIEF.md
# Double-Buffered Register Update Controller

This block holds a bank of configuration registers. Each register has two copies. The host copy takes writes from a simple address/data port. The live copy drives the downstream datapath. The host can make any number of writes, and none of them reach the datapath until an update strobe arrives. The strobe may be asynchronous to the core clock. When it arrives, every host copy moves into its live copy at once, so a group of related settings changes on a single clock edge.

The strobe passes through a two-stage synchronizer and then a rising-edge detector. A strobe held high for many cycles therefore causes only one transfer. If the strobe meets setup to the core clock, the latency from strobe to transfer is fixed. If it misses setup, the transfer can land one cycle later. A one-cycle pulse output marks the cycle in which the new live values first appear.

Top module: `dbr_update_ctrl`

## Requirements
- R1: While rst_ni is low, every host copy and every live copy is zero and xfer_o is 0.
- R2: A host write (we_i=1 at a rising edge) changes only the host copy at addr_i. active_o does not change until a transfer takes place.
- R3: If upd_i is first sampled high at rising edge N, the live copies take the host values at edge N+2. After edge N+1 xfer_o is still 0 and active_o still holds the old values. After edge N+2 xfer_o is 1 and active_o shows the new values.
- R4: A strobe held high for any number of cycles (at least two) causes exactly one transfer. A new transfer needs the strobe to fall and then rise again.
- R5: All writes made since the last transfer move together on one transfer. Registers that were not written keep their previous live values.
- R6: If a host write and a transfer occur at the same edge, the live copy takes the host value from before that write. The new value stays pending until the next transfer.
- R7: With we_i=0, addr_i and wdata_i have no effect on any copy.
- R8: When one address is written several times before a transfer, the last write is the one that is transferred.
- R9: xfer_o is high for exactly one cycle per transfer.
- R10: active_o packs the live copies with register k in bits [k*DATA_W +: DATA_W]. With the defaults there are 8 registers of 32 bits, and addr_i is 3 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core sync clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Host write enable |
| addr_i | input | ADDR_W (3) | Host write address |
| wdata_i | input | DATA_W (32) | Host write data |
| upd_i | input | 1 | Update strobe, may be asynchronous |
| active_o | output | NUM_REGS*DATA_W (256) | Packed live register values |
| xfer_o | output | 1 | One-cycle pulse in the first cycle the new live values are shown |

## Verification
The assertions check on every cycle that the live copies stay stable unless a transfer is detected, and that a detected transfer copies the host values from the previous cycle. They also check that a write lands in its addressed host copy, that the host copies hold when no write is made, and that detection is a single-cycle event followed by the xfer_o pulse. The bench scenarios cover the rest, at the ports:
- the exact two-edge latency from strobe sampling to new outputs;
- that a long strobe yields exactly one pulse;
- that a write colliding with a transfer stays pending;
- that batched writes, repeated writes and ignored writes all appear correctly after a later update.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int unsigned NUM_REGS_DEF    = 8;
  localparam int unsigned DATA_W_DEF      = 32;
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/dbr_strobe_sync.sv
module dbr_strobe_sync #(
  parameter int unsigned SYNC_STAGES = dbr_pkg::SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic det_o,
  output logic xfer_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   xfer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      xfer_q <= det_o;
    end
  end

  // rising edge of synchronized strobe; transfer commits on the next edge
  assign det_o  = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign xfer_o = xfer_q;

  a_r4_single_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |=> !det_o);
  a_r9_pulse_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |=> xfer_o);
  a_r9_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o);
endmodule

// File: rtl/dbr_buffer_bank.sv
module dbr_buffer_bank #(
  parameter int unsigned NUM_REGS = dbr_pkg::NUM_REGS_DEF,
  parameter int unsigned DATA_W   = dbr_pkg::DATA_W_DEF,
  localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [NUM_REGS*DATA_W-1:0] buf_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_buf
    logic [DATA_W-1:0] buf_q;
    logic              sel;
    assign sel = we_i && (addr_i == ADDR_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  buf_q <= '0;
      else if (sel) buf_q <= wdata_i;
    end
    assign buf_o[k*DATA_W +: DATA_W] = buf_q;

    a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(k)) |=> buf_o[k*DATA_W +: DATA_W] == $past(wdata_i));
    a_r7_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> $stable(buf_o[k*DATA_W +: DATA_W]));
  end
endmodule

// File: rtl/dbr_active_bank.sv
module dbr_active_bank #(
  parameter int unsigned NUM_REGS = dbr_pkg::NUM_REGS_DEF,
  parameter int unsigned DATA_W   = dbr_pkg::DATA_W_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [NUM_REGS*DATA_W-1:0] buf_i,
  output logic [NUM_REGS*DATA_W-1:0] active_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_act
    logic [DATA_W-1:0] act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     act_q <= '0;
      else if (load_i) act_q <= buf_i[k*DATA_W +: DATA_W];
    end
    assign active_o[k*DATA_W +: DATA_W] = act_q;
  end

  a_r2_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(active_o));
  a_r5_bulk_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> active_o == $past(buf_i));
endmodule

// File: rtl/dbr_update_ctrl.sv
module dbr_update_ctrl #(
  parameter int unsigned NUM_REGS    = dbr_pkg::NUM_REGS_DEF,
  parameter int unsigned DATA_W      = dbr_pkg::DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = dbr_pkg::SYNC_STAGES_DEF,
  localparam int unsigned ADDR_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       upd_i,
  output logic [NUM_REGS*DATA_W-1:0] active_o,
  output logic                       xfer_o
);
  logic                       det;
  logic [NUM_REGS*DATA_W-1:0] buf_flat;

  dbr_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(upd_i),
    .det_o   (det),
    .xfer_o  (xfer_o)
  );

  dbr_buffer_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .buf_o  (buf_flat)
  );

  dbr_active_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_act (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (det),
    .buf_i   (buf_flat),
    .active_o(active_o)
  );

  a_r1_reset_idle: assert property (@(posedge clk_i) !rst_ni |-> (!xfer_o && active_o == '0));
  a_r3_change_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_o) |-> xfer_o);
endmodule

// File: tb/dbr_update_ctrl_tb.sv
module dbr_update_ctrl_tb;
  localparam int NR = 8;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          upd = 1'b0;
  logic [NR*DW-1:0] active;
  logic          xfer;

  logic [NR*DW-1:0] buf_m = '0;
  logic [NR*DW-1:0] act_m = '0;
  int n_run = 0;
  int n_fail = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbr_update_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .upd_i(upd), .active_o(active), .xfer_o(xfer)
  );

  always @(negedge clk) if (rst_n && xfer) pulses++;

  task automatic chk_vec(string req, logic [NR*DW-1:0] got, logic [NR*DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s active=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic chk_bit(string req, logic got, logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s xfer=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic host_write(logic [AW-1:0] a, logic [DW-1:0] d, logic en);
    @(negedge clk);
    we = en; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (en) buf_m[a*DW +: DW] = d;
  endtask

  // strobe held for hold cycles (>=4); checks R3 latency and R9 pulse width
  task automatic update(int hold);
    @(negedge clk); upd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_bit("R3 no pulse after N+1", xfer, 1'b0);
    chk_vec("R3 old values after N+1", active, act_m);
    @(negedge clk);
    act_m = buf_m;
    chk_bit("R3 pulse after N+2", xfer, 1'b1);
    chk_vec("R3/R5 new values after N+2", active, act_m);
    @(negedge clk);
    chk_bit("R9 pulse one cycle", xfer, 1'b0);
    repeat (hold - 4) @(negedge clk);
    upd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // host write lands on the same edge as the transfer (R6)
  task automatic update_collide(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); upd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    act_m = buf_m;
    buf_m[a*DW +: DW] = d;
    chk_vec("R6 transfer takes old host value", active, act_m);
    repeat (2) @(negedge clk);
    upd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pat(int k);
    return 32'hA5000000 ^ (k * 32'h01010101);
  endfunction

  initial begin
    int p0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk_vec("R1 active zero in reset", active, '0);
    chk_bit("R1 xfer low in reset", xfer, 1'b0);
    rst_n = 1'b1;
    update(4);
    chk_vec("R1 host copies zero after reset", active, '0);

    // R2: writes alone never reach the outputs
    for (int k = 0; k < NR; k++) host_write(AW'(k), pat(k), 1'b1);
    repeat (4) @(negedge clk);
    chk_vec("R2 active unchanged before update", active, act_m);
    update(4);
    chk_vec("R10 packing after update", active[3*DW +: DW], {224'd0, pat(3)});

    // R4: long strobe, one transfer
    host_write(3'd1, 32'h1111_0001, 1'b1);
    p0 = pulses;
    update(12);
    n_run++;
    if (pulses - p0 != 1) begin
      n_fail++;
      $display("FAIL R4 pulses=%0d expected=1", pulses - p0);
    end
    chk_vec("R4 values after long strobe", active, act_m);

    // R7: disabled write ignored
    host_write(3'd2, 32'hDEAD_BEEF, 1'b0);
    update(4);
    chk_vec("R7 disabled write ignored", active, act_m);

    // R8: last write wins
    host_write(3'd5, 32'h0000_0001, 1'b1);
    host_write(3'd5, 32'h0000_0002, 1'b1);
    host_write(3'd5, 32'h0000_0003, 1'b1);
    update(5);
    chk_vec("R8 last write wins", active, act_m);

    // R6: collision, then pending value moves on next update
    update_collide(3'd6, 32'hCAFE_0006);
    update(4);
    chk_vec("R6 pending value moves next update", active, act_m);

    // R5: random batches
    for (int it = 0; it < 40; it++) begin
      int nw = 1 + int'($urandom_range(0, 5));
      for (int w = 0; w < nw; w++)
        host_write(AW'($urandom_range(0, NR - 1)), $urandom, ($urandom_range(0, 3) != 0));
      chk_vec("R2 random batch held", active, act_m);
      update(4 + int'($urandom_range(0, 4)));
      chk_vec("R5 random batch transferred", active, act_m);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule